// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early-Refresh Fault

This block is a supervisory timer that asks for a system reset when software stops servicing it on time, and also when software services it too soon. A 7-bit counter steps down once per prescaled tick. Software may reload it only after the count has dropped to or below a programmable window value. A reload that arrives while the count is still above the window counts as a fault. If no reload arrives at all, the count leaves the 0x40..0x7F range and that also counts as a fault. In both cases the block issues a one-cycle reset request. A second output tells an early fault apart from a timeout.

Software reaches the block through a small write port with three registers. The control register at address 0 loads the counter and starts the timer. Bit 7 of its data starts the timer, and bits 6:0 are the load value. The configuration register at address 1 holds the window in bits 6:0, the prescaler selector N in bits 9:8 and the warning enable in bit 10. The status register is at address 2, and any write to it clears the warning flag. The tick period is `BASE_DIV << N` clock cycles, with `BASE_DIV` defaulting to 4096. The block does not wait for an outside reset after a fault. It returns its counter, its enable and its configuration to their reset values in the same cycle that it raises the request.

Top module: `wwdt_top`

## Requirements
- R1: After reset the counter reads 0x7F, the timer is inactive, the warning flag is 0, both reset outputs are 0, the window is 0x7F, N is 0 and the warning is disabled.
- R2: A control write with data bit 7 set starts the timer and loads bits 6:0. Once started, the timer cannot be stopped by any write: a later control write with bit 7 clear leaves it active.
- R3: While active, the counter decrements by one each tick. A tick occurs every `BASE_DIV << N` cycles, counted from the last control write.
- R4: A control write while active, with the count at or below the window value, reloads the counter with data bits 6:0.
- R5: A control write while active, with the count above the window value, raises `rst_req` together with `rst_early` = 1.
- R6: When a tick arrives with the count at 0x40 and no control write in that cycle, the block raises `rst_req` with `rst_early` = 0.
- R7: A control write that would leave the timer active with data bit 6 clear raises `rst_req` with `rst_early` = 1.
- R8: When the warning is enabled, the warning flag sets on the tick that takes the count from 0x41 to 0x40, and a status write clears it. When the warning is disabled, the flag stays 0.
- R9: `rst_req` lasts exactly one cycle. In the cycle it is raised, the counter, the enable, the flag and the configuration all return to their R1 values.
- R10: A valid control write has priority over a timeout tick in the same cycle: the counter reloads and no reset is raised.
- R11: A control write while inactive with bit 7 clear only loads the counter, with no window check and no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 configuration, 2 status |
| wr_data | input | DATA_W | Write data |
| wd_cnt | output | 7 | Current counter value |
| wd_active | output | 1 | Timer running |
| warn_flag | output | 1 | Early-warning flag |
| rst_req | output | 1 | One-cycle system reset request |
| rst_early | output | 1 | Qualifies `rst_req`: 1 for a bad or early refresh, 0 for a timeout |

## Verification
Results that follow a register write appear on the outputs right after the clock edge that takes the write. The counter, the enable, the reset request and the reset cause are all registered. The bench drives its inputs and samples its outputs on falling edges, so a check made just after a write task sees that edge's result.

After a control write, the n-th decrement falls on the edge `n * (BASE_DIV << N)` after the write edge. A timeout from a load L therefore arrives `(L - 0x3F)` ticks after the load. The bench uses `BASE_DIV = 4`. Every wait count in its vector table is worked out from this edge count, and it samples once on each side of the edges that matter: the first tick, the warning tick, the timeout tick and a refresh placed on the timeout edge.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

   localparam int CNT_W = 7;

   localparam logic [CNT_W-1:0] CNT_RST  = 7'h7F;
   localparam logic [CNT_W-1:0] CNT_LAST = 7'h40;
   localparam logic [CNT_W-1:0] CNT_PREW = 7'h41;

   localparam int CTRL_RUN_BIT  = 7;
   localparam int CTRL_MSB_BIT  = 6;
   localparam int CFG_PSC_LSB   = 8;
   localparam int CFG_WARN_BIT  = 10;
   localparam int PSC_W         = 2;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_CFG  = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } wwdt_sel_e;

   typedef struct packed {
      logic [CNT_W-1:0] window;
      logic [PSC_W-1:0] psc;
      logic             warn_en;
   } wwdt_cfg_t;

   localparam wwdt_cfg_t CFG_RST = '{window: 7'h7F, psc: 2'd0, warn_en: 1'b0};

endpackage

// File: rtl/wwdt_prescaler.sv
module wwdt_prescaler
   import wwdt_pkg::*;
#(
   parameter int BASE_DIV = 4096
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PSC_W-1:0] psc,
   output logic             tick
);

   localparam int NSEL   = 1 << PSC_W;
   localparam int MAXDIV = BASE_DIV << (NSEL - 1);
   localparam int PW     = $clog2(MAXDIV);

   generate
      if (BASE_DIV < 2) begin : g_bad_div
         $error("wwdt_prescaler: BASE_DIV must be at least 2");
      end
   endgenerate

   logic [PW-1:0] lim_m1 [NSEL];

   for (genvar i = 0; i < NSEL; i++) begin : g_lim
      assign lim_m1[i] = PW'((BASE_DIV << i) - 1);
   end

   logic [PW-1:0] pre_q;

   assign tick = run && (pre_q == lim_m1[psc]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (!run || restart || tick) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

endmodule

// File: rtl/wwdt_regs.sv
module wwdt_regs
   import wwdt_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              fault,
   output wwdt_cfg_t         cfg,
   output logic              ctrl_wr,
   output logic              stat_wr,
   output logic [7:0]        ctrl_data
);

   generate
      if (DATA_W < CFG_WARN_BIT + 1) begin : g_bad_width
         $error("wwdt_regs: DATA_W too narrow for the configuration fields");
      end
   endgenerate

   wwdt_sel_e sel;
   logic      cfg_wr;

   assign sel       = wwdt_sel_e'(wr_addr);
   assign ctrl_wr   = wr_en && (sel == SEL_CTRL);
   assign cfg_wr    = wr_en && (sel == SEL_CFG);
   assign stat_wr   = wr_en && (sel == SEL_STAT);
   assign ctrl_data = wr_data[7:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= CFG_RST;
      end else if (fault) begin
         cfg <= CFG_RST;
      end else if (cfg_wr) begin
         cfg.window  <= wr_data[CNT_W-1:0];
         cfg.psc     <= wr_data[CFG_PSC_LSB +: PSC_W];
         cfg.warn_en <= wr_data[CFG_WARN_BIT];
      end
   end

endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
   import wwdt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ctrl_wr,
   input  logic [7:0]       ctrl_data,
   input  logic             stat_wr,
   input  wwdt_cfg_t        cfg,
   output logic [CNT_W-1:0] cnt_q,
   output logic             en_q,
   output logic             warn_q,
   output logic             rst_q,
   output logic             early_q,
   output logic             fault
);

   logic refresh, start, bad_load, too_early, timeout, early_fault, warn_set;

   always_comb begin
      refresh     = ctrl_wr && en_q;
      start       = ctrl_wr && !en_q && ctrl_data[CTRL_RUN_BIT];
      bad_load    = (refresh || start) && !ctrl_data[CTRL_MSB_BIT];
      too_early   = refresh && (cnt_q > cfg.window);
      timeout     = en_q && tick && !ctrl_wr && (cnt_q == CNT_LAST);
      early_fault = bad_load || too_early;
      fault       = early_fault || timeout;
      warn_set    = cfg.warn_en && en_q && tick && !ctrl_wr && (cnt_q == CNT_PREW);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= CNT_RST;
         en_q    <= 1'b0;
         warn_q  <= 1'b0;
         rst_q   <= 1'b0;
         early_q <= 1'b0;
      end else begin
         rst_q   <= fault;
         early_q <= early_fault;
         if (fault) begin
            cnt_q  <= CNT_RST;
            en_q   <= 1'b0;
            warn_q <= 1'b0;
         end else begin
            if (ctrl_wr) begin
               cnt_q <= ctrl_data[CNT_W-1:0];
               en_q  <= en_q | ctrl_data[CTRL_RUN_BIT];
            end else if (en_q && tick) begin
               cnt_q <= cnt_q - 1'b1;
            end
            if (warn_set) begin
               warn_q <= 1'b1;
            end else if (stat_wr) begin
               warn_q <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
   import wwdt_pkg::*;
#(
   parameter int BASE_DIV = 4096,
   parameter int DATA_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [6:0]        wd_cnt,
   output logic              wd_active,
   output logic              warn_flag,
   output logic              rst_req,
   output logic              rst_early
);

   wwdt_cfg_t  cfg;
   logic       ctrl_wr, stat_wr, tick, fault;
   logic [7:0] ctrl_data;

   wwdt_regs #(.DATA_W(DATA_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .fault     (fault),
      .cfg       (cfg),
      .ctrl_wr   (ctrl_wr),
      .stat_wr   (stat_wr),
      .ctrl_data (ctrl_data)
   );

   wwdt_prescaler #(.BASE_DIV(BASE_DIV)) i_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (wd_active),
      .restart (ctrl_wr),
      .psc     (cfg.psc),
      .tick    (tick)
   );

   wwdt_core i_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .ctrl_wr   (ctrl_wr),
      .ctrl_data (ctrl_data),
      .stat_wr   (stat_wr),
      .cfg       (cfg),
      .cnt_q     (wd_cnt),
      .en_q      (wd_active),
      .warn_q    (warn_flag),
      .rst_q     (rst_req),
      .early_q   (rst_early),
      .fault     (fault)
   );

endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [1:0] wr_addr,
   input logic [6:0] wd_cnt,
   input logic       wd_active,
   input logic       warn_flag,
   input logic       rst_req,
   input logic       rst_early
);

   a_r9_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   a_r2_no_stop : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_active) |-> rst_req);

   a_r3_step : assert property (@(posedge clk) disable iff (!rst_n)
      (wd_active && $past(wd_active) && !$past(wr_en && wr_addr == 2'd0))
      |-> (wd_cnt == $past(wd_cnt) || wd_cnt == $past(wd_cnt) - 7'd1));

   a_r6_timeout_at_last : assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && !rst_early) |-> ($past(wd_cnt) == 7'h40 && $past(wd_active)));

   a_r5_early_needs_write : assert property (@(posedge clk) disable iff (!rst_n)
      rst_early |-> (rst_req && $past(wr_en && wr_addr == 2'd0)));

   a_r8_warn_at_last : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(warn_flag) |-> (wd_cnt == 7'h40));

endmodule

bind wwdt_top wwdt_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wd_cnt    (wd_cnt),
   .wd_active (wd_active),
   .warn_flag (warn_flag),
   .rst_req   (rst_req),
   .rst_early (rst_early)
);

// File: tb/test_wwdt_top.sv
`timescale 1ns/1ps
module test_wwdt_top;

   localparam int DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_addr = 2'd0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [6:0]        wd_cnt;
   logic              wd_active, warn_flag, rst_req, rst_early;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   wwdt_top #(.BASE_DIV(4), .DATA_W(DATA_W)) i_wwdt_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wd_cnt    (wd_cnt),
      .wd_active (wd_active),
      .warn_flag (warn_flag),
      .rst_req   (rst_req),
      .rst_early (rst_early)
   );

   typedef struct packed {
      logic        wr;
      logic [1:0]  addr;
      logic [15:0] data;
      logic [7:0]  wt;
      logic [6:0]  cnt;
      logic        en;
      logic        rst;
      logic        early;
      logic        warn;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 2'd1, 16'h0450, 8'd0,  7'h7F, 1'b0, 1'b0, 1'b0, 1'b0},
      '{1'b1, 2'd0, 16'h00FF, 8'd0,  7'h7F, 1'b1, 1'b0, 1'b0, 1'b0},
      '{1'b0, 2'd0, 16'h0000, 8'd8,  7'h7D, 1'b1, 1'b0, 1'b0, 1'b0},
      '{1'b1, 2'd0, 16'h007F, 8'd0,  7'h7F, 1'b0, 1'b1, 1'b1, 1'b0},
      '{1'b0, 2'd0, 16'h0000, 8'd1,  7'h7F, 1'b0, 1'b0, 1'b0, 1'b0},
      '{1'b1, 2'd1, 16'h0450, 8'd0,  7'h7F, 1'b0, 1'b0, 1'b0, 1'b0},
      '{1'b1, 2'd0, 16'h00D5, 8'd0,  7'h55, 1'b1, 1'b0, 1'b0, 1'b0},
      '{1'b0, 2'd0, 16'h0000, 8'd20, 7'h50, 1'b1, 1'b0, 1'b0, 1'b0},
      '{1'b1, 2'd0, 16'h0058, 8'd0,  7'h58, 1'b1, 1'b0, 1'b0, 1'b0},
      '{1'b0, 2'd0, 16'h0000, 8'd92, 7'h41, 1'b1, 1'b0, 1'b0, 1'b0},
      '{1'b0, 2'd0, 16'h0000, 8'd4,  7'h40, 1'b1, 1'b0, 1'b0, 1'b1},
      '{1'b1, 2'd2, 16'h0000, 8'd0,  7'h40, 1'b1, 1'b0, 1'b0, 1'b0},
      '{1'b0, 2'd0, 16'h0000, 8'd3,  7'h7F, 1'b0, 1'b1, 1'b0, 1'b0},
      '{1'b0, 2'd0, 16'h0000, 8'd1,  7'h7F, 1'b0, 1'b0, 1'b0, 1'b0}
   };

   // Row tags: cfg write (R1), start (R2), two ticks (R3), early refresh (R5),
   // one-cycle pulse (R9), re-cfg (R9), start at 0x55 (R2), count to window (R3),
   // refresh at window (R4), count down (R3), warning (R8), clear warning (R8),
   // timeout (R6), pulse end (R9)
   localparam string VREQ [NV] = '{"R1", "R2", "R3", "R5", "R9", "R9", "R2",
                                   "R3", "R4", "R3", "R8", "R8", "R6", "R9"};

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hard_reset();
      rst_n = 1'b0;
      wr_en = 1'b0;
      wait_cyc(2);
      rst_n = 1'b1;
      wait_cyc(1);
   endtask

   task automatic chk(input string req, input logic [6:0] ec, input logic ee,
                      input logic er, input logic eerl, input logic ew);
      checks++;
      if (wd_cnt !== ec || wd_active !== ee || rst_req !== er ||
          rst_early !== eerl || warn_flag !== ew) begin
         errors++;
         $display("FAIL %s: cnt=%h act=%b rst=%b early=%b warn=%b expected cnt=%h act=%b rst=%b early=%b warn=%b",
                  req, wd_cnt, wd_active, rst_req, rst_early, warn_flag,
                  ec, ee, er, eerl, ew);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      hard_reset();
      // R1: reset state
      chk("R1", 7'h7F, 1'b0, 1'b0, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
         wait_cyc(int'(VEC[i].wt));
         chk(VREQ[i], VEC[i].cnt, VEC[i].en, VEC[i].rst, VEC[i].early, VEC[i].warn);
      end

      // R11: load while inactive without the start bit
      wr(2'd0, 16'h0070);
      chk("R11", 7'h70, 1'b0, 1'b0, 1'b0, 1'b0);

      // R2: start, then a write with bit 7 clear keeps it running.
      // R9: the window is back at 0x7F after the timeout, so a refresh at 0x7F is accepted.
      wr(2'd0, 16'h00FF);
      chk("R2", 7'h7F, 1'b1, 1'b0, 1'b0, 1'b0);
      wr(2'd0, 16'h0060);
      chk("R9", 7'h60, 1'b1, 1'b0, 1'b0, 1'b0);

      // R7: refresh data with bit 6 clear
      wr(2'd0, 16'h0030);
      chk("R7", 7'h7F, 1'b0, 1'b1, 1'b1, 1'b0);
      wait_cyc(1);

      // R3: N=2 gives 16 cycles per tick
      wr(2'd1, 16'h027F);
      wr(2'd0, 16'h00FF);
      wait_cyc(15);
      chk("R3", 7'h7F, 1'b1, 1'b0, 1'b0, 1'b0);
      wait_cyc(1);
      chk("R3", 7'h7E, 1'b1, 1'b0, 1'b0, 1'b0);

      // R8: the warning stays 0 while disabled
      hard_reset();
      wr(2'd0, 16'h00C2);
      wait_cyc(8);
      chk("R8", 7'h40, 1'b1, 1'b0, 1'b0, 1'b0);

      // R10: a refresh on the same edge as the timeout tick wins
      hard_reset();
      wr(2'd0, 16'h00C1);
      wait_cyc(7);
      wr(2'd0, 16'h0050);
      chk("R10", 7'h50, 1'b1, 1'b0, 1'b0, 1'b0);

      // R6: a start with bit 7 clear on an active timer, then timeout from 0x41
      wr(2'd0, 16'h0041);
      wait_cyc(7);
      chk("R6", 7'h40, 1'b1, 1'b0, 1'b0, 1'b0);
      wait_cyc(1);
      chk("R6", 7'h7F, 1'b0, 1'b1, 1'b0, 1'b0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule